// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Century Bit

This block keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours in 24-hour form, day of week, day of month, month and a two-digit year. An optional century bit can flip each time the year wraps. Time moves forward one second for each single-cycle pulse on `sec_tick`. The prescaler that makes that pulse lives outside the block. A host write port loads any of the seven register images. A stop bit freezes timekeeping. An oscillator monitor watches per-slot presence strobes and latches a fail flag after a run of missing pulses.

The seven outputs are the register images at addresses 0 to 6. A host serial interface reads them directly. Out-of-range BCD digits written by the host are not corrected. They count on from the written value until the digit wraps naturally. After every accepted write to a time field, the block raises `phase_clr` for one cycle, so the external prescaler can restart its sub-second phase and the next second is a full second.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, the register images read as follows. Address 0 (stop bit 7, seconds) is 0x00. Address 1 (fail flag bit 7, minutes) is 0x80. Address 2 (century enable bit 7, century bit 6, hours) is 0x00. Day of week is 0x01, date is 0x01, month is 0x01 and year is 0x00. `phase_clr` is 0.
- R2: With the stop bit 0, each `sec_tick` pulse advances the time by one second in BCD. Seconds and minutes go from 59 to 00, and hours go from 23 to 00. Each wrap carries into the next field, so a carry can run from seconds all the way to the year in one cycle.
- R3: While the stop bit (address 0, bit 7) is 1, `sec_tick` has no effect and every time field holds its value.
- R4: Day of week runs 1 to 7 and goes from 7 to 1 at each day carry. A stored 0 becomes 1 on the next day carry.
- R5: At the day carry, the date wraps to 01 and the month advances after the last day of the month. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the BCD year is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and advances the year.
- R6: The year wraps from 99 to 00. At that wrap, the century bit (address 2, bit 6) inverts when century enable (address 2, bit 7) is 1, and is unchanged when century enable is 0.
- R7: A digit above its valid range counts on from where it is. A units digit above 9 increments and wraps from F to 0 with no carry into the tens digit. A tens digit carries in from a units 9 and counts modulo its field width (seconds tens 6, then 7, then 0) with no carry out.
- R8: With `wr_en` high and `wr_addr` from 0 to 6, the addressed image loads from `wr_data` at the next edge. The field layouts are:
  - address 0: bit 7 is stop, bits 6:0 are seconds;
  - address 1: bits 6:0 are minutes; writing 0 to bit 7 clears the fail flag and writing 1 leaves it unchanged;
  - address 2: bit 7 is century enable, bit 6 is century, bits 5:0 are hours;
  - address 3: bits 2:0 are day of week;
  - address 4: bits 5:0 are date;
  - address 5: bits 4:0 are month;
  - address 6: all eight bits are year.

  Unused bits read 0. A write to address 7 changes nothing.
- R9: `phase_clr` is 1 for exactly the one cycle that follows an accepted write to addresses 0 to 6. A `sec_tick` in the same cycle as such a write is dropped.
- R10: The fail flag sets on the edge that samples the fourth consecutive `osc_slot` strobe with `osc_seen` low. A strobe with `osc_seen` high restarts the run.
- R11: A `bkup_sw` pulse clears the fail flag and the miss run. The time fields, century bits and stop bit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, first power-up |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address, 0 to 6 valid |
| wr_data | input | 8 | Host write data in register image layout |
| osc_slot | input | 1 | Strobe marking one expected oscillator pulse slot |
| osc_seen | input | 1 | Oscillator pulse present in the current slot |
| bkup_sw | input | 1 | Pulse on switchover to the backup supply |
| sec_reg | output | 8 | Image 0: stop bit and seconds |
| min_reg | output | 8 | Image 1: fail flag and minutes |
| hour_reg | output | 8 | Image 2: century enable, century, hours |
| dow_reg | output | 8 | Image 3: day of week |
| date_reg | output | 8 | Image 4: date |
| month_reg | output | 8 | Image 5: month |
| year_reg | output | 8 | Image 6: year |
| phase_clr | output | 1 | Prescaler phase restart, one cycle after a time write |

## Verification
Every register image changes on the same rising edge that samples the tick, write, slot strobe or backup pulse, because the whole carry chain is combinational within that cycle. `phase_clr` comes one edge after the write. The bench drives each stimulus on a falling edge for one cycle and reads the images at the following falling edge, which is half a cycle after the only edge that can change them. It reads `phase_clr` at that same falling edge and again one cycle later, to confirm it lasts a single cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   typedef enum logic [2:0] {
      A_SEC   = 3'd0,
      A_MIN   = 3'd1,
      A_HOUR  = 3'd2,
      A_DOW   = 3'd3,
      A_DATE  = 3'd4,
      A_MONTH = 3'd5,
      A_YEAR  = 3'd6
   } cal_addr_e;

   localparam logic [2:0] LAST_ADDR = 3'd6;

   // BCD year divisible by four: even tens with units 0/4/8, odd tens with 2/6
   function automatic logic bcd_leap(input logic [7:0] yr);
      logic [3:0] u;
      u = yr[3:0];
      if (!yr[4]) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
      else        return (u == 4'd2) || (u == 4'd6);
   endfunction

   function automatic logic [5:0] month_end(input logic [4:0] mon, input logic [7:0] yr);
      case (mon)
         5'h02:                      return bcd_leap(yr) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bcd_pair.sv
module rtc_bcd_pair #(
   parameter int          TENS_W  = 3,
   parameter logic [7:0]  RST_VAL = 8'h00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld,
   input  logic [TENS_W+3:0]   ld_val,
   input  logic                inc,
   input  logic [TENS_W+3:0]   max_val,
   input  logic [TENS_W+3:0]   min_val,
   output logic [TENS_W+3:0]   q,
   output logic                carry
);
   localparam int W = TENS_W + 4;

   if (TENS_W < 1 || TENS_W > 4) begin : g_bad_width
      $error("rtc_bcd_pair: TENS_W must be 1..4");
   end

   logic [TENS_W-1:0] tens;
   logic [3:0]        units;
   logic [W-1:0]      nxt;

   assign tens  = q[W-1:4];
   assign units = q[3:0];
   assign carry = inc && !ld && (q == max_val);

   always_comb begin
      if (q == max_val)       nxt = min_val;
      else if (units == 4'd9) nxt = {tens + TENS_W'(1), 4'd0};
      else                    nxt = {tens, units + 4'd1};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL[W-1:0];
      else if (ld)    q <= ld_val;
      else if (inc)   q <= nxt;
   end

   // R2
   wrap_to_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && q == max_val) |=> (q == $past(min_val)));

   // R7
   units_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && q[3:0] == 4'hF) |=> (q[3:0] == 4'h0 && q[W-1:4] == $past(q[W-1:4])));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !ld) |=> $stable(q));

endmodule

// File: rtl/rtc_dow_counter.sv
module rtc_dow_counter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [2:0] ld_val,
   input  logic       inc,
   output logic [2:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 3'd1;
      else if (ld)    q <= ld_val;
      else if (inc)   q <= (q == 3'd7) ? 3'd1 : q + 3'd1;
   end

   // R4
   dow_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld) |=> (q != 3'd0));

endmodule

// File: rtl/rtc_osc_monitor.sv
module rtc_osc_monitor #(
   parameter int MISS_LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot,
   input  logic seen,
   input  logic bkup,
   input  logic host_clr,
   output logic fail
);
   if (MISS_LIMIT < 1) begin : g_bad_limit
      $error("rtc_osc_monitor: MISS_LIMIT must be at least 1");
   end

   logic miss;
   logic run_full;

   assign miss = slot && !seen;

   if (MISS_LIMIT == 1) begin : g_no_count
      assign run_full = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(MISS_LIMIT);
      localparam logic [CW-1:0] TOP = CW'(MISS_LIMIT - 1);
      logic [CW-1:0] run;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 run <= '0;
         else if (bkup)              run <= '0;
         else if (slot && seen)      run <= '0;
         else if (miss && run != TOP) run <= run + CW'(1);
      end

      assign run_full = (run == TOP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                fail <= 1'b1;
      else if (bkup)             fail <= 1'b0;
      else if (miss && run_full) fail <= 1'b1;
      else if (host_clr)         fail <= 1'b0;
   end

   // R11
   bkup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bkup |=> !fail);

   // R10
   no_false_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !miss |=> !$rose(fail));

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
   import rtc_cal_pkg::*;
#(
   parameter int MISS_LIMIT  = 4,
   parameter bit HAS_CENTURY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       osc_slot,
   input  logic       osc_seen,
   input  logic       bkup_sw,
   output logic [7:0] sec_reg,
   output logic [7:0] min_reg,
   output logic [7:0] hour_reg,
   output logic [7:0] dow_reg,
   output logic [7:0] date_reg,
   output logic [7:0] month_reg,
   output logic [7:0] year_reg,
   output logic       phase_clr
);
   logic       wr_hit, adv, stop, fail;
   logic       ld_sec, ld_min, ld_hour, ld_dow, ld_date, ld_mon, ld_year;
   logic       c_sec, c_min, c_hour, c_date, c_mon, c_year;
   logic [6:0] sec_q, min_q;
   logic [5:0] hour_q, date_q, date_max;
   logic [4:0] mon_q;
   logic [7:0] year_q;
   logic [2:0] dow_q;
   logic       cent_en, cent;

   assign wr_hit  = wr_en && (wr_addr <= LAST_ADDR);
   assign ld_sec  = wr_en && (wr_addr == A_SEC);
   assign ld_min  = wr_en && (wr_addr == A_MIN);
   assign ld_hour = wr_en && (wr_addr == A_HOUR);
   assign ld_dow  = wr_en && (wr_addr == A_DOW);
   assign ld_date = wr_en && (wr_addr == A_DATE);
   assign ld_mon  = wr_en && (wr_addr == A_MONTH);
   assign ld_year = wr_en && (wr_addr == A_YEAR);

   // a host write owns the cycle: the coincident tick is dropped
   assign adv = sec_tick && !stop && !wr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop      <= 1'b0;
         phase_clr <= 1'b0;
      end else begin
         if (ld_sec) stop <= wr_data[7];
         phase_clr <= wr_hit;
      end
   end

   rtc_bcd_pair #(.TENS_W(3), .RST_VAL(8'h00)) u_sec (
      .clk(clk), .rst_n(rst_n), .ld(ld_sec), .ld_val(wr_data[6:0]), .inc(adv),
      .max_val(7'h59), .min_val(7'h00), .q(sec_q), .carry(c_sec));

   rtc_bcd_pair #(.TENS_W(3), .RST_VAL(8'h00)) u_min (
      .clk(clk), .rst_n(rst_n), .ld(ld_min), .ld_val(wr_data[6:0]), .inc(c_sec),
      .max_val(7'h59), .min_val(7'h00), .q(min_q), .carry(c_min));

   rtc_bcd_pair #(.TENS_W(2), .RST_VAL(8'h00)) u_hour (
      .clk(clk), .rst_n(rst_n), .ld(ld_hour), .ld_val(wr_data[5:0]), .inc(c_min),
      .max_val(6'h23), .min_val(6'h00), .q(hour_q), .carry(c_hour));

   rtc_dow_counter u_dow (
      .clk(clk), .rst_n(rst_n), .ld(ld_dow), .ld_val(wr_data[2:0]), .inc(c_hour),
      .q(dow_q));

   assign date_max = month_end(mon_q, year_q);

   rtc_bcd_pair #(.TENS_W(2), .RST_VAL(8'h01)) u_date (
      .clk(clk), .rst_n(rst_n), .ld(ld_date), .ld_val(wr_data[5:0]), .inc(c_hour),
      .max_val(date_max), .min_val(6'h01), .q(date_q), .carry(c_date));

   rtc_bcd_pair #(.TENS_W(1), .RST_VAL(8'h01)) u_mon (
      .clk(clk), .rst_n(rst_n), .ld(ld_mon), .ld_val(wr_data[4:0]), .inc(c_date),
      .max_val(5'h12), .min_val(5'h01), .q(mon_q), .carry(c_mon));

   rtc_bcd_pair #(.TENS_W(4), .RST_VAL(8'h00)) u_year (
      .clk(clk), .rst_n(rst_n), .ld(ld_year), .ld_val(wr_data), .inc(c_mon),
      .max_val(8'h99), .min_val(8'h00), .q(year_q), .carry(c_year));

   if (HAS_CENTURY) begin : g_century
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cent_en <= 1'b0;
            cent    <= 1'b0;
         end else if (ld_hour) begin
            cent_en <= wr_data[7];
            cent    <= wr_data[6];
         end else if (c_year && cent_en) begin
            cent    <= ~cent;
         end
      end

      // R6
      cent_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (c_year && cent_en) |=> (cent != $past(cent)));

      // R6
      cent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (c_year && !cent_en) |=> $stable(cent));
   end else begin : g_no_century
      assign cent_en = 1'b0;
      assign cent    = 1'b0;
   end

   rtc_osc_monitor #(.MISS_LIMIT(MISS_LIMIT)) u_osc (
      .clk(clk), .rst_n(rst_n), .slot(osc_slot), .seen(osc_seen), .bkup(bkup_sw),
      .host_clr(ld_min && !wr_data[7]), .fail(fail));

   assign sec_reg   = {stop, sec_q};
   assign min_reg   = {fail, min_q};
   assign hour_reg  = {cent_en, cent, hour_q};
   assign dow_reg   = {5'd0, dow_q};
   assign date_reg  = {2'd0, date_q};
   assign month_reg = {3'd0, mon_q};
   assign year_reg  = year_q;

   // R3
   stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !wr_hit) |=> $stable(sec_reg));

   // R9
   phase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> phase_clr);

   // R11
   bkup_keep_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bkup_sw && !wr_hit && !sec_tick) |=> ($stable(sec_reg) && $stable(hour_reg)));

endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0, wr_en = 1'b0, osc_slot = 1'b0, osc_seen = 1'b0, bkup_sw = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] sec_reg, min_reg, hour_reg, dow_reg, date_reg, month_reg, year_reg;
   logic       phase_clr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rtc_bcd_calendar dut_i (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .osc_slot(osc_slot), .osc_seen(osc_seen), .bkup_sw(bkup_sw),
      .sec_reg(sec_reg), .min_reg(min_reg), .hour_reg(hour_reg), .dow_reg(dow_reg),
      .date_reg(date_reg), .month_reg(month_reg), .year_reg(year_reg), .phase_clr(phase_clr));

   // op 0 = write, 1 = ticks, 2 = check ; {op, addr, 3'b0, data}
   function automatic logic [15:0] vw(input int a, input int d);
      return {2'd0, 3'(a), 3'd0, 8'(d)};
   endfunction
   function automatic logic [15:0] vt(input int n);
      return {2'd1, 3'd0, 3'd0, 8'(n)};
   endfunction
   function automatic logic [15:0] vc(input int a, input int d);
      return {2'd2, 3'(a), 3'd0, 8'(d)};
   endfunction

   localparam int NV = 105;
   localparam logic [15:0] VEC [NV] = '{
      // R2 R4 R5 R6: full chain to year wrap, century enabled
      vw(6,'h99), vw(5,'h12), vw(4,'h31), vw(3,'h07), vw(2,'hE3), vw(1,'h59), vw(0,'h59), vt(1),
      vc(0,'h00), vc(1,'h00), vc(2,'h80), vc(3,'h01), vc(4,'h01), vc(5,'h01), vc(6,'h00),
      // R5 leap February (year 12), then Feb 29 -> Mar 01
      vw(6,'h12), vw(5,'h02), vw(4,'h28), vw(2,'h23), vw(1,'h59), vw(0,'h59), vt(1),
      vc(4,'h29), vc(5,'h02),
      vw(2,'h23), vw(1,'h59), vw(0,'h59), vt(1), vc(4,'h01), vc(5,'h03),
      // R5 common February (year 26)
      vw(6,'h26), vw(5,'h02), vw(4,'h28), vw(2,'h23), vw(1,'h59), vw(0,'h59), vt(1),
      vc(4,'h01), vc(5,'h03),
      // R5 30-day month
      vw(5,'h04), vw(4,'h30), vw(2,'h23), vw(1,'h59), vw(0,'h59), vt(1), vc(4,'h01), vc(5,'h05),
      // R5 31-day month does not wrap at 30
      vw(5,'h05), vw(4,'h30), vw(2,'h23), vw(1,'h59), vw(0,'h59), vt(1), vc(4,'h31), vc(5,'h05),
      // R6 century disabled: century bit kept
      vw(6,'h99), vw(5,'h12), vw(4,'h31), vw(2,'h63), vw(1,'h59), vw(0,'h59), vt(1),
      vc(2,'h40), vc(6,'h00), vc(5,'h01),
      // R4 day of week written 0
      vw(3,'h00), vw(2,'h23), vw(1,'h59), vw(0,'h59), vt(1), vc(3,'h01),
      // R7 invalid digits
      vw(0,'h5E), vt(1), vc(0,'h5F), vt(1), vc(0,'h50), vc(1,'h00),
      vw(0,'h69), vt(1), vc(0,'h70), vw(0,'h79), vt(1), vc(0,'h00), vc(1,'h00),
      // R3 stop
      vw(0,'h85), vt(5), vc(0,'h85), vw(0,'h05), vt(2), vc(0,'h07),
      // R2 units carry into tens
      vw(0,'h58), vw(1,'h09), vt(2), vc(0,'h00), vc(1,'h10),
      vw(2,'h09), vw(1,'h59), vw(0,'h59), vt(1), vc(2,'h10), vc(1,'h00),
      // R8 address 7 ignored
      vw(7,'hFF), vc(0,'h00), vc(1,'h00), vc(2,'h10)
   };

   function automatic logic [7:0] img(input logic [2:0] a);
      case (a)
         3'd0: return sec_reg;
         3'd1: return min_reg;
         3'd2: return hour_reg;
         3'd3: return dow_reg;
         3'd4: return date_reg;
         3'd5: return month_reg;
         3'd6: return year_reg;
         default: return 8'hXX;
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         sec_tick = 1'b1;
         @(negedge clk);
         sec_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic slots(input int n, input logic present);
      for (int i = 0; i < n; i++) begin
         osc_slot = 1'b1; osc_seen = present;
         @(negedge clk);
      end
      osc_slot = 1'b0; osc_seen = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 sec", sec_reg, 8'h00);
      check("R1 min", min_reg, 8'h80);
      check("R1 hour", hour_reg, 8'h00);
      check("R1 dow", dow_reg, 8'h01);
      check("R1 date", date_reg, 8'h01);
      check("R1 month", month_reg, 8'h01);
      check("R1 year", year_reg, 8'h00);
      check("R1 phase_clr", {7'd0, phase_clr}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         case (VEC[v][15:14])
            2'd0: host_wr(VEC[v][13:11], VEC[v][7:0]);
            2'd1: ticks(int'(VEC[v][7:0]));
            default: check($sformatf("vector %0d (R2-group table)", v),
                           img(VEC[v][13:11]), VEC[v][7:0]);
         endcase
      end

      // R9 phase_clr lasts one cycle after a write
      host_wr(3'd0, 8'h10);
      check("R9 phase_clr high", {7'd0, phase_clr}, 8'h01);
      @(negedge clk);
      check("R9 phase_clr low", {7'd0, phase_clr}, 8'h00);
      // R9 tick coinciding with write is dropped
      wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h05; sec_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; sec_tick = 1'b0;
      check("R9 tick dropped", sec_reg, 8'h10);
      check("R8 dow loaded", dow_reg, 8'h05);

      // R10 fail flag run of misses
      host_wr(3'd1, 8'h12);
      check("R8 flag cleared by 0", min_reg, 8'h12);
      slots(3, 1'b0);
      slots(1, 1'b1);
      slots(3, 1'b0);
      check("R10 three misses", min_reg, 8'h12);
      slots(1, 1'b0);
      check("R10 fourth miss", min_reg, 8'h92);
      host_wr(3'd1, 8'hA0);
      check("R8 write 1 keeps flag", min_reg, 8'hA0);

      // R11 backup switchover
      host_wr(3'd0, 8'h85);
      slots(3, 1'b0);
      bkup_sw = 1'b1;
      @(negedge clk);
      bkup_sw = 1'b0;
      check("R11 flag cleared", min_reg, 8'h20);
      check("R11 stop and seconds kept", sec_reg, 8'h85);
      check("R11 hours kept", hour_reg, 8'h10);
      slots(3, 1'b0);
      check("R11 miss run restarted", min_reg, 8'h20);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule